// File: doc/BRIEF.md
# Streaming Matrix Product Engine with Operand Caches

This block forms the product of an A matrix of ROWS x INNER elements and a B matrix of INNER x COLS elements, where both operands arrive one element at a time on FIFO-style read ports and the products leave one element at a time on a FIFO-style write port. No operand element is ever requested twice: the current row of A is kept in a small row cache and the whole of B is kept in a local copy that is filled while the first result row is produced.

Each result is an unsigned inner product computed in full precision from the caches. It is formed in a combinational accumulator that starts from zero and is pushed to the output exactly once, with its final value. Results leave in row-major order. A start pulse launches a run; a done level reports that the last result has been pushed. Dimensions and element width are fixed at elaboration.

Top module: `mm_stream`

## Requirements
- R1: While and after reset, before any start, done_o is low and a_rd_o, b_rd_o and r_wr_o are all low.
- R2: start_i launches a run when the block is idle or done, and clears done_o on the next cycle; start_i seen while a run is in progress has no effect on the pops, results or their order.
- R3: The A stream is row-major, INNER elements per row. The INNER elements of row i are popped only while result column 0 is pending, so when result (i,j) is written exactly (i+1)*INNER A elements have been popped; ROWS*INNER in total per run.
- R4: The B stream delivers column j as its INNER elements in index order. B is popped only while result row 0 is pending, so when result (i,j) is written exactly INNER*(j+1) B elements have been popped if i = 0 and INNER*COLS otherwise.
- R5: Result (i,j) equals the unsigned sum over k of A[i][k]*B[k][j], with r_data_o being 2*DW+clog2(INNER) bits wide so no overflow occurs.
- R6: Each of the ROWS*COLS results is written once, in row-major order (column index inside row index); a result write never coincides with an operand pop.
- R7: A pop (a_rd_o, b_rd_o) is issued only when the matching empty flag is low and counts as a pop in that cycle; r_wr_o is issued only when r_full_i is low. While the write is blocked by r_full_i the pending r_data_o stays stable, and no data is lost across any stall pattern.
- R8: Without stalls, the first result of a run is written INNER+1 cycles after the cycle in which start_i is sampled, and in every result row after the first, columns 1..COLS-1 are written in consecutive cycles.
- R9: done_o rises in the cycle after the last result is written, stays high until the next start, and while it is high no pop or write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a run when idle or done |
| done_o | output | 1 | High after the final result has been written |
| a_data_i | input | DW | Head element of the A stream |
| a_empty_i | input | 1 | A stream has no element |
| a_rd_o | output | 1 | Pop the A stream this cycle |
| b_data_i | input | DW | Head element of the B stream |
| b_empty_i | input | 1 | B stream has no element |
| b_rd_o | output | 1 | Pop the B stream this cycle |
| r_data_o | output | 2*DW+clog2(INNER) | Result element |
| r_full_i | input | 1 | Result stream cannot accept |
| r_wr_o | output | 1 | Push r_data_o this cycle |

## Verification
Operand pops and result writes are combinational decisions on the current state and flags, so they are due in the same cycle as the flags that permit them, while the cache contents they fill are visible one cycle later. The bench drives all flags at the falling edge and samples the strobes shortly after, counting each strobe as a transfer at the next rising edge; every written result is then compared with an inner product computed in the bench and with the pop counts that row-major caching implies. Without stalls the first write is expected INNER+1 sampled cycles after start and later-row columns one cycle apart, and done_o is expected in the sample after the final write.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WRITE,
    ST_DONE
  } mm_state_e;

  function automatic int res_width(input int dw, input int n);
    return 2 * dw + $clog2(n);
  endfunction

endpackage

// File: rtl/mm_dot.sv
module mm_dot #(
  parameter int DW    = 8,
  parameter int INNER = 4,
  parameter int RW    = 18
) (
  input  logic [INNER-1:0][DW-1:0] a_i,
  input  logic [INNER-1:0][DW-1:0] b_i,
  output logic [RW-1:0]            sum_o
);

  logic [INNER-1:0][RW-1:0] prod;

  for (genvar k = 0; k < INNER; k++) begin : g_mul
    assign prod[k] = RW'(a_i[k]) * RW'(b_i[k]);
  end

  // accumulator starts at zero for every result
  always_comb begin
    sum_o = '0;
    for (int k = 0; k < INNER; k++) sum_o = sum_o + prod[k];
  end

endmodule

// File: rtl/mm_cache.sv
module mm_cache #(
  parameter int DW    = 8,
  parameter int INNER = 4,
  parameter int COLS  = 3,
  localparam int KW   = $clog2(INNER + 1),
  localparam int CW   = $clog2(COLS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     a_we_i,
  input  logic [KW-1:0]            a_idx_i,
  input  logic [DW-1:0]            a_data_i,
  input  logic                     b_we_i,
  input  logic [CW-1:0]            b_col_i,
  input  logic [KW-1:0]            b_idx_i,
  input  logic [DW-1:0]            b_data_i,
  input  logic [CW-1:0]            rd_col_i,
  output logic [INNER-1:0][DW-1:0] a_row_o,
  output logic [INNER-1:0][DW-1:0] b_col_o
);

  logic [INNER-1:0][DW-1:0]            a_row_q;
  logic [COLS-1:0][INNER-1:0][DW-1:0]  b_mem_q;

  for (genvar k = 0; k < INNER; k++) begin : g_arow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             a_row_q[k] <= '0;
      else if (a_we_i && a_idx_i == KW'(k))    a_row_q[k] <= a_data_i;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_bcol
    for (genvar k = 0; k < INNER; k++) begin : g_belem
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          b_mem_q[c][k] <= '0;
        else if (b_we_i && b_col_i == CW'(c) && b_idx_i == KW'(k))
          b_mem_q[c][k] <= b_data_i;
      end
    end
  end

  assign a_row_o = a_row_q;
  assign b_col_o = b_mem_q[rd_col_i];

endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int ROWS  = 3,
  parameter int INNER = 4,
  parameter int COLS  = 3,
  localparam int KW   = $clog2(INNER + 1),
  localparam int CW   = $clog2(COLS),
  localparam int IW   = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          a_empty_i,
  input  logic          b_empty_i,
  input  logic          r_full_i,
  output logic          a_rd_o,
  output logic          b_rd_o,
  output logic          r_wr_o,
  output logic          done_o,
  output logic [KW-1:0] a_idx_o,
  output logic [KW-1:0] b_idx_o,
  output logic [IW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output mm_state_e     state_o
);

  mm_state_e     state_q;
  logic [IW-1:0] row_q, row_n;
  logic [CW-1:0] col_q, col_n;
  logic [KW-1:0] a_cnt_q, b_cnt_q;
  logic          a_need, b_need, a_fin, b_fin;
  logic          last_col, last_row;

  assign a_need   = a_cnt_q != KW'(INNER);
  assign b_need   = b_cnt_q != KW'(INNER);
  assign a_rd_o   = (state_q == ST_LOAD) && a_need && !a_empty_i;
  assign b_rd_o   = (state_q == ST_LOAD) && b_need && !b_empty_i;
  assign a_fin    = !a_need || (a_rd_o && a_cnt_q == KW'(INNER - 1));
  assign b_fin    = !b_need || (b_rd_o && b_cnt_q == KW'(INNER - 1));
  assign r_wr_o   = (state_q == ST_WRITE) && !r_full_i;
  assign done_o   = state_q == ST_DONE;

  assign last_col = col_q == CW'(COLS - 1);
  assign last_row = row_q == IW'(ROWS - 1);
  assign row_n    = last_col ? row_q + IW'(1) : row_q;
  assign col_n    = last_col ? '0 : col_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      a_cnt_q <= KW'(INNER);
      b_cnt_q <= KW'(INNER);
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q <= ST_LOAD;
            row_q   <= '0;
            col_q   <= '0;
            a_cnt_q <= '0;
            b_cnt_q <= '0;
          end
        end
        ST_LOAD: begin
          if (a_rd_o) a_cnt_q <= a_cnt_q + KW'(1);
          if (b_rd_o) b_cnt_q <= b_cnt_q + KW'(1);
          if (a_fin && b_fin) state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          if (r_wr_o) begin
            if (last_row && last_col) begin
              state_q <= ST_DONE;
            end else begin
              row_q <= row_n;
              col_q <= col_n;
              // reload A at row start, B during first row
              if (col_n == '0 || row_n == '0) begin
                state_q <= ST_LOAD;
                a_cnt_q <= (col_n == '0) ? '0 : KW'(INNER);
                b_cnt_q <= (row_n == '0) ? '0 : KW'(INNER);
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign a_idx_o = a_cnt_q;
  assign b_idx_o = b_cnt_q;
  assign row_o   = row_q;
  assign col_o   = col_q;
  assign state_o = state_q;

endmodule

// File: rtl/mm_stream.sv
module mm_stream
  import mm_pkg::*;
#(
  parameter int  ROWS  = 3,
  parameter int  INNER = 4,
  parameter int  COLS  = 3,
  parameter int  DW    = 8,
  localparam int RW    = res_width(DW, INNER)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          done_o,
  input  logic [DW-1:0] a_data_i,
  input  logic          a_empty_i,
  output logic          a_rd_o,
  input  logic [DW-1:0] b_data_i,
  input  logic          b_empty_i,
  output logic          b_rd_o,
  output logic [RW-1:0] r_data_o,
  input  logic          r_full_i,
  output logic          r_wr_o
);

  localparam int KW = $clog2(INNER + 1);
  localparam int CW = $clog2(COLS);
  localparam int IW = $clog2(ROWS);

  logic [KW-1:0]            a_idx, b_idx;
  logic [IW-1:0]            row_w;
  logic [CW-1:0]            col_w;
  mm_state_e                state_w;
  logic [INNER-1:0][DW-1:0] a_row, b_col;

  mm_ctrl #(.ROWS(ROWS), .INNER(INNER), .COLS(COLS)) ctrl_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .a_empty_i(a_empty_i),
    .b_empty_i(b_empty_i),
    .r_full_i (r_full_i),
    .a_rd_o   (a_rd_o),
    .b_rd_o   (b_rd_o),
    .r_wr_o   (r_wr_o),
    .done_o   (done_o),
    .a_idx_o  (a_idx),
    .b_idx_o  (b_idx),
    .row_o    (row_w),
    .col_o    (col_w),
    .state_o  (state_w)
  );

  mm_cache #(.DW(DW), .INNER(INNER), .COLS(COLS)) cache_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .a_we_i  (a_rd_o),
    .a_idx_i (a_idx),
    .a_data_i(a_data_i),
    .b_we_i  (b_rd_o),
    .b_col_i (col_w),
    .b_idx_i (b_idx),
    .b_data_i(b_data_i),
    .rd_col_i(col_w),
    .a_row_o (a_row),
    .b_col_o (b_col)
  );

  mm_dot #(.DW(DW), .INNER(INNER), .RW(RW)) dot_i (
    .a_i  (a_row),
    .b_i  (b_col),
    .sum_o(r_data_o)
  );

endmodule

// File: rtl/mm_stream_chk.sv
module mm_stream_chk
  import mm_pkg::*;
#(
  parameter int RW = 18,
  parameter int IW = 2,
  parameter int CW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          a_empty_i,
  input logic          b_empty_i,
  input logic          r_full_i,
  input logic          a_rd_o,
  input logic          b_rd_o,
  input logic          r_wr_o,
  input logic          done_o,
  input logic [RW-1:0] r_data_o,
  input logic [IW-1:0] row_w,
  input logic [CW-1:0] col_w,
  input mm_state_e     state_w
);

  // R7
  a_pop_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rd_o |-> !a_empty_i);

  // R7
  b_pop_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_rd_o |-> !b_empty_i);

  // R7
  r_push_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_wr_o |-> !r_full_i);

  // R7
  r_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_WRITE && r_full_i) |=> $stable(r_data_o));

  // R3
  a_row_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rd_o |-> col_w == '0);

  // R4
  b_first_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_rd_o |-> row_w == '0);

  // R6
  wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_wr_o |-> !(a_rd_o || b_rd_o));

  // R9
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(r_wr_o));

  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(a_rd_o || b_rd_o || r_wr_o));

endmodule

bind mm_stream mm_stream_chk #(.RW(RW), .IW(IW), .CW(CW)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_empty_i(a_empty_i),
  .b_empty_i(b_empty_i),
  .r_full_i (r_full_i),
  .a_rd_o   (a_rd_o),
  .b_rd_o   (b_rd_o),
  .r_wr_o   (r_wr_o),
  .done_o   (done_o),
  .r_data_o (r_data_o),
  .row_w    (row_w),
  .col_w    (col_w),
  .state_w  (state_w)
);

// File: tb/mm_stream_tb_top.sv
module mm_stream_tb_top;

  localparam int ROWS  = 3;
  localparam int INNER = 4;
  localparam int COLS  = 3;
  localparam int DW    = 8;
  localparam int RW    = 2 * DW + $clog2(INNER);
  localparam int CLK_P = 10;
  localparam int NA    = ROWS * INNER;
  localparam int NB    = COLS * INNER;
  localparam int NR    = ROWS * COLS;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          start_i;
  logic          done_o;
  logic [DW-1:0] a_data_i, b_data_i;
  logic          a_empty_i, b_empty_i, r_full_i;
  logic          a_rd_o, b_rd_o, r_wr_o;
  logic [RW-1:0] r_data_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [DW-1:0] a_q [NA];
  logic [DW-1:0] b_q [NB];

  always #(CLK_P / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mm_stream #(.ROWS(ROWS), .INNER(INNER), .COLS(COLS), .DW(DW)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .done_o   (done_o),
    .a_data_i (a_data_i),
    .a_empty_i(a_empty_i),
    .a_rd_o   (a_rd_o),
    .b_data_i (b_data_i),
    .b_empty_i(b_empty_i),
    .b_rd_o   (b_rd_o),
    .r_data_o (r_data_o),
    .r_full_i (r_full_i),
    .r_wr_o   (r_wr_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic fill(input int p);
    for (int x = 0; x < NA; x++) begin
      case (p)
        0: a_q[x] = DW'(x + 1);
        1: a_q[x] = '1;
        2: a_q[x] = DW'((x * 37 + 11) % 256);
        default: a_q[x] = ((x / INNER) == (x % INNER)) ? DW'(200) : '0;
      endcase
    end
    for (int x = 0; x < NB; x++) begin
      case (p)
        0: b_q[x] = DW'(2 * x + 3);
        1: b_q[x] = '1;
        2: b_q[x] = DW'((x * 91 + 5) % 256);
        default: b_q[x] = DW'((x * 53 + 7) % 256);
      endcase
    end
  endtask

  function automatic bit a_stall(input int m, input int c);
    return (m == 1) ? (c % 3 == 1) : (m == 3) ? (c % 5 == 0 || c % 7 == 3) : 1'b0;
  endfunction
  function automatic bit b_stall(input int m, input int c);
    return (m == 1) ? (c % 4 == 2) : (m == 3) ? (c % 3 == 0) : 1'b0;
  endfunction
  function automatic bit r_stall(input int m, input int c);
    return (m == 2) ? (c % 2 == 0) : (m == 3) ? (c % 4 == 1) : 1'b0;
  endfunction

  task automatic run(input int p, input int mode, input bit inject);
    int a_ptr = 0, b_ptr = 0, r_ptr = 0, last_w = 0, it = 0;
    bit fin = 0;
    fill(p);
    while (!fin && it < 3000) begin
      @(negedge clk);
      start_i   = (it == 0) || (inject && it == 5);
      a_data_i  = (a_ptr < NA) ? a_q[a_ptr] : '0;
      b_data_i  = (b_ptr < NB) ? b_q[b_ptr] : '0;
      a_empty_i = (a_ptr >= NA) || a_stall(mode, cyc);
      b_empty_i = (b_ptr >= NB) || b_stall(mode, cyc);
      r_full_i  = r_stall(mode, cyc);
      #1;
      if (it == 1) chk(done_o == 1'b0, "R2 start clears done", done_o, 0);
      if (a_rd_o) a_ptr++;
      if (b_rd_o) b_ptr++;
      if (r_wr_o) begin
        int i = r_ptr / COLS;
        int j = r_ptr % COLS;
        longint exp = 0;
        for (int k = 0; k < INNER; k++)
          exp += longint'(a_q[i * INNER + k]) * longint'(b_q[j * INNER + k]);
        chk(longint'(r_data_o) == exp, "R5 result value", r_data_o, exp);
        chk(a_ptr == (i + 1) * INNER, "R3 A pops at write", a_ptr, (i + 1) * INNER);
        chk(b_ptr == ((i == 0) ? (j + 1) : COLS) * INNER, "R4 B pops at write",
            b_ptr, ((i == 0) ? (j + 1) : COLS) * INNER);
        chk(done_o == 1'b0, "R9 done before last write", done_o, 0);
        if (mode == 0 && r_ptr == 0) chk(it == INNER + 1, "R8 first latency", it, INNER + 1);
        if (mode == 0 && i > 0 && j > 0) chk(it == last_w + 1, "R8 back-to-back", it, last_w + 1);
        last_w = it;
        r_ptr++;
        if (r_ptr == NR) fin = 1;
      end
      it++;
    end
    chk(r_ptr == NR, "R6 result count", r_ptr, NR);
    start_i   = 1'b0;
    a_empty_i = 1'b0;
    b_empty_i = 1'b0;
    r_full_i  = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      chk(done_o == 1'b1, "R9 done held", done_o, 1);
      chk(!(a_rd_o || b_rd_o || r_wr_o), "R9 quiet when done",
          {a_rd_o, b_rd_o, r_wr_o}, 0);
    end
    chk(a_ptr == NA, "R3 total A pops", a_ptr, NA);
    chk(b_ptr == NB, "R4 total B pops", b_ptr, NB);
    if (inject) chk(r_ptr == NR && a_ptr == NA, "R2 start ignored while busy", r_ptr, NR);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    rst_ni    = 1'b0;
    start_i   = 1'b0;
    a_data_i  = '0;
    b_data_i  = '0;
    a_empty_i = 1'b0;
    b_empty_i = 1'b0;
    r_full_i  = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(!(done_o || a_rd_o || b_rd_o || r_wr_o), "R1 quiet in reset",
        {done_o, a_rd_o, b_rd_o, r_wr_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!(done_o || a_rd_o || b_rd_o || r_wr_o), "R1 quiet after reset",
        {done_o, a_rd_o, b_rd_o, r_wr_o}, 0);

    run(0, 0, 1'b0);
    run(1, 0, 1'b0);
    run(2, 1, 1'b0);
    run(3, 2, 1'b0);
    run(2, 3, 1'b1);
    run(0, 3, 1'b0);
    run(1, 2, 1'b1);
    run(3, 0, 1'b0);

    summary();
    $finish;
  end

endmodule